// File: doc/BRIEF.md
# Performance-State Transition Trigger Register

This block is an 8-bit control register on a simple register bus. Its only live bit selects the target performance state of the processor. Every accepted write starts a transition. During a transition the block pulls the active-low stop-clock output low for a fixed number of clock cycles. It then releases the output and raises a one-cycle completion pulse for the transition sequencer downstream. A write is accepted even when it carries the value already stored, so software can repeat a transition on purpose.

A global enable input controls whether the register is active. While the enable is low, the register ignores writes and reads as zero. A write that lands while a transition is still running updates the stored bit at once and queues exactly one further transition. That transition starts one cycle after the current one releases stop-clock.

Top module: `pstate_trigger_reg`

## Requirements
- R1: Bit 0 holds the target state (0 = high-power, 1 = low-power). Bits 7:1 always read 0, and write data in those bits has no effect.
- R2: While `en` is 1, `rd_data[0]` returns the bit 0 value of the most recent accepted write, from the cycle after that write onward.
- R3: An accepted write (`wr_en` and `en` both 1) while `busy` is 0 drives `stop_n` low and `busy` high from the next cycle on.
- R4: `stop_n` stays low for exactly `HOLD_CYCLES` cycles. It then returns high, and `busy` falls in the same cycle.
- R5: `done` is a one-cycle pulse, high exactly in the first cycle after `stop_n` returns high.
- R6: A write of the value already stored starts a full transition, exactly like a write that changes the value.
- R7: Accepted writes while `busy` is 1 update the stored bit and queue one more transition. Any number of such writes queue only one. The queued transition drives `stop_n` low again one cycle after the release, and a write in that gap cycle merges into it.
- R8: While `en` is 0, `rd_data` is 00h, and a write changes neither the stored bit nor starts a transition. A transition already running still completes.
- R9: After reset the stored byte is 01h, `stop_n` is 1, `busy` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable; 0 makes the register inert and read as zero |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 8 | Write data; only bit 0 is stored |
| rd_data | output | 8 | Read data, combinational from stored state and `en` |
| stop_n | output | 1 | Active-low processor stop-clock |
| busy | output | 1 | High while stop-clock is held |
| done | output | 1 | One-cycle completion pulse after release |

## Verification
The bench tests transitions with three kinds of write: a single isolated write, a repeat of the stored value, and a burst of writes inside one hold window. Comparing the first two shows that a transition does not depend on whether the value changed. The burst shows that several pending writes collapse into one extra transition with a one-cycle gap. The bench also issues writes with the enable low, writes with the reserved bits set, and a long stretch of randomly timed writes and enable toggles. These show whether writes are correctly ignored while disabled, and whether the queue handles writes that land on the release or gap cycle.

// File: rtl/pstrig_pkg.sv
// Package: shared types for the performance-state trigger register.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package pstrig_pkg;
    // Sequencer states: waiting, or holding stop-clock low.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_t;

    localparam int unsigned REG_W = 8;
    localparam logic [REG_W-1:0] REG_RESET = 8'h01;
    localparam logic [REG_W-1:0] REG_WMASK = 8'h01;
endpackage

// File: rtl/pstrig_statereg.sv
// Stores the target-state byte and forms the read value.
// Assumes wr_accept already includes the enable; reserved bits are masked.
module pstrig_statereg
    import pstrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_accept,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] reg_q;

    // Capture masked write data on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= REG_RESET;
        else if (wr_accept)
            reg_q <= wr_data & REG_WMASK;
    end

    // Read as zero while disabled.
    always_comb begin
        rd_data = en ? reg_q : '0;
    end
endmodule

// File: rtl/pstrig_hold_timer.sv
// Down-counter for the stop-clock hold window.
// Assumes HOLD_CYCLES >= 1; load restarts the count at HOLD_CYCLES-1.
module pstrig_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Last hold cycle reached.
    always_comb begin
        expired = (cnt_q == '0);
    end
endmodule

// File: rtl/pstrig_sequencer.sv
// Transition sequencer: launches holds, queues one pending request,
// drives stop-clock, busy and the completion pulse.
// Assumes expired is only meaningful while holding.
module pstrig_sequencer
    import pstrig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic expired,
    output logic load,
    output logic stop_n,
    output logic busy,
    output logic done
);
    seq_state_t state_q;
    logic       pend_q;
    logic       done_q;

    // Start a hold when idle and a request is present.
    always_comb begin
        load = (state_q == SEQ_IDLE) && (wr_accept || pend_q);
    end

    // State, pending flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    done_q <= 1'b0;
                    if (load) begin
                        state_q <= SEQ_HOLD;
                        pend_q  <= 1'b0;
                    end
                end
                default: begin
                    if (wr_accept)
                        pend_q <= 1'b1;
                    if (expired) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        done_q  <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy   = (state_q == SEQ_HOLD);
        stop_n = !busy;
        done   = done_q;
    end
endmodule

// File: rtl/pstate_trigger_reg.sv
// Top: performance-state trigger register. Any enabled write stores bit 0
// and launches a stop-clock hold of HOLD_CYCLES cycles.
// Assumes base-address decode is done outside; wr_en means "this register".
module pstate_trigger_reg
    import pstrig_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       stop_n,
    output logic       busy,
    output logic       done
);
    logic wr_accept;
    logic load;
    logic expired;

    // A write counts only while enabled.
    always_comb begin
        wr_accept = wr_en && en;
    end

    pstrig_statereg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wr_accept (wr_accept),
        .wr_data   (wr_data),
        .rd_data   (rd_data)
    );

    pstrig_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .expired (expired)
    );

    pstrig_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .expired   (expired),
        .load      (load),
        .stop_n    (stop_n),
        .busy      (busy),
        .done      (done)
    );
endmodule

// File: rtl/pstrig_checker.sv
// Checker bound to the top: port-level temporal properties.
// Assumes the top's port names; hold length measured with a local counter.
module pstrig_checker #(
    parameter int unsigned HOLD_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       stop_n,
    input logic       busy,
    input logic       done
);
    int unsigned low_cnt;

    // Count consecutive cycles with stop-clock held low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= 0;
        else if (!stop_n)
            low_cnt <= low_cnt + 1;
        else
            low_cnt <= 0;
    end

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:1] == 7'd0);

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en) |=> (!en || rd_data[0] == $past(wr_data[0])));

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && !busy) |=> (!stop_n && busy));

    a_r4_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_n) |-> (low_cnt == HOLD_CYCLES));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_n) |-> done);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_disabled_read: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rd_data == 8'h00));

    a_r8_disabled_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && wr_en && !busy && stop_n && !done) |=> stop_n);
endmodule

bind pstate_trigger_reg pstrig_checker #(.HOLD_CYCLES(HOLD_CYCLES)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .stop_n  (stop_n),
    .busy    (busy),
    .done    (done)
);

// File: tb/test_pstate_trigger_reg.sv
// Bench: behavioural reference model compared at every falling edge.
module test_pstate_trigger_reg;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       stop_n, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R9 reset";
    bit finished = 1'b0;

    // Reference model state.
    int m_state = 1;
    bit m_active = 0;
    int m_left = 0;
    bit m_pend = 0;
    bit m_done = 0;

    always #4 clk = ~clk;

    pstate_trigger_reg #(.HOLD_CYCLES(HOLD)) i_pstate_trigger_reg (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .stop_n(stop_n), .busy(busy), .done(done)
    );

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 1; m_active = 0; m_left = 0; m_pend = 0; m_done = 0;
        end else begin
            bit wa;
            wa = wr_en && en;
            if (wa) m_state = wr_data[0];
            if (!m_active) begin
                m_done = 0;
                if (wa || m_pend) begin
                    m_active = 1; m_left = HOLD; m_pend = 0;
                end
            end else begin
                if (wa) m_pend = 1;
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_active = 0; m_done = 1;
                end else begin
                    m_done = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Full output comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " rd_data"}, int'(rd_data), en ? m_state : 0);
            check({phase, " stop_n"}, int'(stop_n), m_active ? 0 : 1);
            check({phase, " busy"}, int'(busy), int'(m_active));
            check({phase, " done"}, int'(done), int'(m_done));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset rd_data", int'(rd_data), 8'h01);
        check("R9 reset stop_n", int'(stop_n), 1);
        check("R9 reset busy", int'(busy), 0);
        check("R9 reset done", int'(done), 0);

        phase = "R3 R4 R5 single write";
        wr(8'h00);
        check("R3 stop low after write", int'(stop_n), 0);
        check("R2 readback 0", int'(rd_data), 8'h00);
        idle(HOLD + 3);

        phase = "R6 same-value write";
        wr(8'h00);
        check("R6 repeat write starts hold", int'(busy), 1);
        idle(HOLD + 3);

        phase = "R7 burst while busy";
        wr(8'h01);
        wr(8'h00);
        wr(8'h01);
        wr(8'h00);
        check("R7 bit updated while busy", int'(rd_data), 8'h00);
        idle(3 * HOLD);

        phase = "R8 disabled";
        en = 1'b0;
        wr(8'h01);
        check("R8 no transition", int'(stop_n), 1);
        check("R8 read zero", int'(rd_data), 8'h00);
        idle(2);
        en = 1'b1;
        @(negedge clk);
        check("R8 bit unchanged", int'(rd_data), 8'h00);

        phase = "R1 reserved bits";
        wr(8'hFF);
        check("R1 reserved read 0", int'(rd_data), 8'h01);
        idle(HOLD + 2);
        wr(8'hFE);
        check("R1 bit0 only", int'(rd_data), 8'h00);
        idle(HOLD + 2);

        phase = "R7 random timing";
        for (int i = 0; i < 600; i++) begin
            wr_en = ($urandom_range(0, 5) == 0);
            wr_data = 8'($urandom);
            en = ($urandom_range(0, 7) != 0);
            @(negedge clk);
        end
        wr_en = 1'b0; en = 1'b1;
        idle(3 * HOLD);
        finish_run();
    end
endmodule